// File: doc/BRIEF.md
# Programmable-Index Direct-Mapped Cache

This block is a single-port cache that keeps the one-line lookup of a direct-mapped cache while spreading heavily used index values over several physical lines. The word address is split into three fields. The low bits pick a group of lines by fixed decode. The next bits are a programmable index, matched in parallel against a small content-addressable entry kept for each line of that group. The remaining high bits are the tag. The decode index (group plus programmable field) is three bits wider than the index of a plain direct-mapped array with the same number of lines, so the tag is three bits narrower. With the default parameters, the mapping factor 2^(PI+NPI)/2^OI is 8 and each group holds 2^OI/2^NPI = 4 lines.

A request is looked up in the cycle it is presented. At most one decoder entry matches, and that line's tag is compared. A matching entry with a matching tag is a hit: read data is returned, or write data is stored, in the same cycle. If an entry matches but the tag differs, the same line is refilled and its decoder entry stays as it is. If no entry matches, a victim line in the group is chosen and its decoder entry is rewritten with the new programmable index. The victim is the lowest-numbered invalid line if there is one; otherwise the low bits of a free-running 8-bit LFSR pick it. Lines are write-back and write-allocate.

The controller has three states. IDLE performs lookups. EVICT writes back a dirty victim. REFILL reads the new line. The transitions are:
- IDLE → IDLE on a hit or when there is no request.
- IDLE → EVICT on any miss, which also latches the victim and the new address.
- EVICT → REFILL when the victim is clean, or on the memory acknowledge of its write-back.
- REFILL → IDLE on the memory acknowledge, which installs the line.

The requester holds its request until `cpu_hit` is seen, so after a miss the held request completes as a hit once the line is installed.

Top module: `pdec_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1 and `cpu_hit` is 0, and the first access to any address misses.
- R2: The word address is split as group = addr[NPI-1:0], programmable index = addr[NPI+PI-1:NPI], tag = the remaining upper bits. Read data on a hit is always the latest value written to that address, or the memory contents if the address was never written.
- R3: A request that hits raises `cpu_hit` in the cycle it is presented, with valid `cpu_rdata`. A write hit completes in that cycle and causes no memory transaction.
- R4: When the decoder matches but the tag differs, exactly the matched line is refilled. The other lines of the group keep hitting.
- R5: On a decoder miss, an invalid line of the group is used first, so BAS distinct programmable indices of one group coexist after reset without any eviction.
- R6: On a decoder miss in a full group, exactly one line of that group is replaced. The other BAS-1 lines keep hitting.
- R7: At most one decoder entry of the addressed group matches at any time.
- R8: A dirty victim is written to memory at its own address, with its latest data, before the refill read is issued. A clean victim causes no memory write.
- R9: While a miss is being serviced, `cpu_ready` and `cpu_hit` are 0. `mem_req` is raised only while `cpu_ready` is 0, and the memory address and request hold until acknowledged.
- R10: A write miss allocates the line, and the held request then completes as a hit that stores the data.
- R11: Activity in one group never displaces a line of another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request valid; held until `cpu_hit` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller is in IDLE and can look up |
| cpu_hit | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_hit` |
| mem_req | output | 1 | Next-level transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W | Next-level word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | One-cycle transaction acknowledge |
| mem_rdata | input | DATA_W | Refill data, valid with `mem_ack` |

## Verification
A corrupted decoder entry or valid bit shows up at the ports at the next access to the affected group. It appears either as a hit that returns another address's data, or as a hit count that breaks the one-line-replaced rule on the following probes of that group. A lost dirty bit or a wrong stored tag surfaces only later, when the line is evicted: the write-back is missing or goes to the wrong address, and a read-back after eviction returns stale data. The sweeps therefore probe every line of a group immediately after each targeted miss, and re-read the whole address space after the evictions have taken place.

// File: rtl/pdec_cache_pkg.sv
package pdec_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } cache_state_e;

    localparam int LFSR_W = 8;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] cur);
        return {cur[LFSR_W-2:0], cur[7] ^ cur[5] ^ cur[4] ^ cur[3]};
    endfunction

endpackage

// File: rtl/pdec_lfsr.sv
module pdec_lfsr
    import pdec_cache_pkg::*;
#(
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [LFSR_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= LFSR_W'(1);
        else        q <= lfsr_next(q);
    end

    assign rnd = q[OUT_W-1:0];
endmodule

// File: rtl/pdec_cam.sv
module pdec_cam #(
    parameter int GRP_W = 2,
    parameter int WAY_W = 2,
    parameter int PI_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GRP_W-1:0]       lk_grp,
    input  logic [PI_W-1:0]        lk_pi,
    output logic [(1<<WAY_W)-1:0]  match_vec,
    output logic                   match_any,
    output logic [WAY_W-1:0]       match_way,
    output logic                   free_any,
    output logic [WAY_W-1:0]       free_way,
    input  logic [GRP_W+WAY_W-1:0] vic_line,
    output logic [PI_W-1:0]        vic_pi,
    output logic                   vic_valid,
    input  logic                   wr_en,
    input  logic [GRP_W+WAY_W-1:0] wr_line,
    input  logic [PI_W-1:0]        wr_pi
);
    localparam int WAYS  = 1 << WAY_W;
    localparam int LINES = 1 << (GRP_W + WAY_W);

    logic [PI_W-1:0]  ent_pi [LINES];
    logic [LINES-1:0] ent_v;
    logic [WAYS-1:0]  free_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ent_v <= '0;
        else if (wr_en) ent_v[wr_line] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) ent_pi[wr_line] <= wr_pi;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WIDX = WAY_W'(w);
        assign match_vec[w] = ent_v[{WIDX, lk_grp}] && (ent_pi[{WIDX, lk_grp}] == lk_pi);
        assign free_vec[w]  = !ent_v[{WIDX, lk_grp}];
    end

    always_comb begin
        match_any = 1'b0;
        match_way = '0;
        free_any  = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                match_any = 1'b1;
                match_way = WAY_W'(w);
            end
            if (free_vec[w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    assign vic_pi    = ent_pi[vic_line];
    assign vic_valid = ent_v[vic_line];
endmodule

// File: rtl/pdec_lines.sv
module pdec_lines #(
    parameter int LINE_W = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_dirty,
    input  logic              fill_en,
    input  logic              cpu_wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << LINE_W;

    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [DATA_W-1:0] data_arr [LINES];
    logic [LINES-1:0]  dirty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dirty <= '0;
        else if (fill_en)   dirty[wr_line] <= 1'b0;
        else if (cpu_wr_en) dirty[wr_line] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_arr[wr_line] <= wr_tag;
        if (fill_en || cpu_wr_en) data_arr[wr_line] <= wr_data;
    end

    assign rd_tag   = tag_arr[rd_line];
    assign rd_data  = data_arr[rd_line];
    assign rd_dirty = dirty[rd_line];
endmodule

// File: rtl/pdec_cache.sv
module pdec_cache
    import pdec_cache_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int OI     = 4,
    parameter int NPI    = 2,
    parameter int PI     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int GRP_W  = NPI;
    localparam int WAY_W  = OI - NPI;
    localparam int WAYS   = 1 << WAY_W;
    localparam int TAG_W  = ADDR_W - NPI - PI;
    localparam int LINE_W = OI;

    cache_state_e state_q, state_d;

    logic [GRP_W-1:0] lk_grp;
    logic [PI-1:0]    lk_pi;
    logic [TAG_W-1:0] lk_tag;
    assign lk_grp = cpu_addr[NPI-1:0];
    assign lk_pi  = cpu_addr[NPI+PI-1:NPI];
    assign lk_tag = cpu_addr[ADDR_W-1:NPI+PI];

    logic [WAYS-1:0]  dec_match;
    logic             match_any, free_any, vic_valid;
    logic [WAY_W-1:0] match_way, free_way, rnd_way, sel_way;
    logic [PI-1:0]    vic_pi;

    logic [WAY_W-1:0] v_way_q;
    logic [GRP_W-1:0] v_grp_q;
    logic [PI-1:0]    v_pi_q;
    logic [TAG_W-1:0] v_tag_q;

    logic [LINE_W-1:0] lk_line, v_line, rd_line;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              rd_dirty, lk_hit, capture, fill_en, cpu_wr_en;

    assign lk_line = {match_way, lk_grp};
    assign v_line  = {v_way_q, v_grp_q};
    assign rd_line = (state_q == ST_IDLE) ? lk_line : v_line;
    assign lk_hit  = match_any && (rd_tag == lk_tag);
    assign sel_way = match_any ? match_way : (free_any ? free_way : rnd_way);

    pdec_cam #(.GRP_W(GRP_W), .WAY_W(WAY_W), .PI_W(PI)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_grp    (lk_grp),
        .lk_pi     (lk_pi),
        .match_vec (dec_match),
        .match_any (match_any),
        .match_way (match_way),
        .free_any  (free_any),
        .free_way  (free_way),
        .vic_line  (v_line),
        .vic_pi    (vic_pi),
        .vic_valid (vic_valid),
        .wr_en     (fill_en),
        .wr_line   (v_line),
        .wr_pi     (v_pi_q)
    );

    pdec_lines #(.LINE_W(LINE_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_line   (rd_line),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .rd_dirty  (rd_dirty),
        .fill_en   (fill_en),
        .cpu_wr_en (cpu_wr_en),
        .wr_line   (fill_en ? v_line : lk_line),
        .wr_tag    (v_tag_q),
        .wr_data   (fill_en ? mem_rdata : cpu_wdata)
    );

    pdec_lfsr #(.OUT_W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd_way)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            v_way_q <= '0;
            v_grp_q <= '0;
            v_pi_q  <= '0;
            v_tag_q <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                v_way_q <= sel_way;
                v_grp_q <= lk_grp;
                v_pi_q  <= lk_pi;
                v_tag_q <= lk_tag;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_hit   = 1'b0;
        capture   = 1'b0;
        fill_en   = 1'b0;
        cpu_wr_en = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {v_tag_q, v_pi_q, v_grp_q};
        mem_wdata = rd_data;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                if (cpu_req) begin
                    if (lk_hit) begin
                        cpu_hit   = 1'b1;
                        cpu_wr_en = cpu_we;
                    end else begin
                        capture = 1'b1;
                        state_d = ST_EVICT;
                    end
                end
            end
            ST_EVICT: begin
                if (vic_valid && rd_dirty) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = {rd_tag, vic_pi, v_grp_q};
                    if (mem_ack) state_d = ST_REFILL;
                end else begin
                    state_d = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cpu_rdata = rd_data;
endmodule

// File: rtl/pdec_cache_chk.sv
module pdec_cache_chk #(
    parameter int ADDR_W = 10,
    parameter int WAYS   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              cpu_hit,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WAYS-1:0]   dec_match
);
    assert_no_hit_at_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !cpu_hit);

    assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_match));

    assert_hit_only_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> cpu_ready);

    assert_mem_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    assert_fill_then_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && cpu_req) |=>
            (cpu_hit || !cpu_req || !$stable(cpu_addr)));
endmodule

bind pdec_cache pdec_cache_chk #(.ADDR_W(ADDR_W), .WAYS(1 << (OI - NPI))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .cpu_hit   (cpu_hit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .dec_match (dec_match)
);

// File: tb/pdec_cache_bench.sv
module pdec_cache_bench;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_hit, mem_req, mem_we;
    logic [DATA_W-1:0] cpu_rdata, mem_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    pdec_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OI(4), .NPI(2), .PI(5)) u_pdec_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [DATA_W-1:0] gold [DEPTH];
    logic [DATA_W-1:0] mem  [DEPTH];
    int n_tests = 0, n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0, stall_bad = 0;
    logic [ADDR_W-1:0] last_wb_addr = '0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int t, input int p, input int g);
        return {t[2:0], p[4:0], g[1:0]};
    endfunction

    // next-level memory: acknowledge after two request cycles
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                cnt++;
                if (cnt >= 2) begin
                    if (mem_we) begin
                        wr_cnt++;
                        last_wb_addr = mem_addr;
                        check(mem_wdata == gold[mem_addr], "R8 wb data", int'(mem_wdata), int'(gold[mem_addr]));
                        mem[mem_addr] = mem_wdata;
                    end else begin
                        rd_cnt++;
                        mem_rdata = mem[mem_addr];
                    end
                    mem_ack = 1'b1;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    task automatic access(input logic [ADDR_W-1:0] a, input logic we, input logic [DATA_W-1:0] wd,
                          output bit first_hit, output logic [DATA_W-1:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        first_hit = cpu_hit;
        while (!cpu_hit) begin
            @(negedge clk);
            #1;
            if (cpu_hit && !cpu_ready) stall_bad++;
            if (cpu_ready && mem_req) stall_bad++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        if (we) gold[a] = wd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit h;
        logic [DATA_W-1:0] d;
        int hits, w0, r0;
        for (int i = 0; i < DEPTH; i++) begin
            gold[i] = DATA_W'(i * 37 + 16'h05a5);
            mem[i]  = gold[i];
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ready == 1'b1, "R1 ready after reset", int'(cpu_ready), 1);
        check(cpu_hit == 1'b0, "R1 no hit after reset", int'(cpu_hit), 0);

        // R5: four programmable indices per group fill free lines; R1 first access misses
        for (int g = 0; g < 4; g++)
            for (int p = 0; p < 4; p++) begin
                access(mk(0, p, g), 1'b0, '0, h, d);
                check(h == 1'b0, "R1 first access misses", int'(h), 0);
                check(d == gold[mk(0, p, g)], "R2 refill data", int'(d), int'(gold[mk(0, p, g)]));
            end
        check(wr_cnt == 0, "R8 clean fills write nothing", wr_cnt, 0);
        r0 = rd_cnt;
        // R3 / R5 / R11: all sixteen lines still resident
        for (int g = 0; g < 4; g++)
            for (int p = 0; p < 4; p++) begin
                access(mk(0, p, g), 1'b0, '0, h, d);
                check(h == 1'b1, "R5 R11 resident line hits", int'(h), 1);
                check(d == gold[mk(0, p, g)], "R3 hit data", int'(d), int'(gold[mk(0, p, g)]));
            end
        check(rd_cnt == r0, "R3 hits make no refill", rd_cnt, r0);

        // R6: new index in full group 0 replaces exactly one line
        access(mk(0, 5, 0), 1'b0, '0, h, d);
        check(h == 1'b0, "R6 decoder miss", int'(h), 0);
        hits = 0;
        for (int p = 0; p < 4; p++) begin
            access(mk(0, p, 0), 1'b0, '0, h, d);
            if (h) hits++;
        end
        check(hits == 3, "R6 one line displaced", hits, 3);
        access(mk(0, 5, 0), 1'b0, '0, h, d);
        check(h == 1'b1, "R6 new index resident", int'(h), 1);

        // R4: same index, other tag in group 1 replaces exactly the matched line
        access(mk(5, 2, 1), 1'b0, '0, h, d);
        check(h == 1'b0, "R4 tag miss", int'(h), 0);
        check(d == gold[mk(5, 2, 1)], "R4 refill data", int'(d), int'(gold[mk(5, 2, 1)]));
        hits = 0;
        for (int p = 0; p < 4; p++) if (p != 2) begin
            access(mk(0, p, 1), 1'b0, '0, h, d);
            if (h) hits++;
        end
        check(hits == 3, "R4 siblings kept", hits, 3);
        access(mk(0, 2, 1), 1'b0, '0, h, d);
        check(h == 1'b0, "R4 matched line was refilled", int'(h), 0);
        // R11: group 2 and 3 untouched by groups 0 and 1
        access(mk(0, 3, 2), 1'b0, '0, h, d);
        check(h == 1'b1, "R11 group 2 intact", int'(h), 1);
        access(mk(0, 0, 3), 1'b0, '0, h, d);
        check(h == 1'b1, "R11 group 3 intact", int'(h), 1);

        // R3 write hit, then R8 write-back on tag conflict
        w0 = wr_cnt; r0 = rd_cnt;
        access(mk(0, 1, 2), 1'b1, 16'h1234, h, d);
        check(h == 1'b1, "R3 write hit", int'(h), 1);
        check(wr_cnt == w0 && rd_cnt == r0, "R3 write hit no traffic", wr_cnt + rd_cnt, w0 + r0);
        access(mk(3, 1, 2), 1'b0, '0, h, d);
        check(wr_cnt == w0 + 1, "R8 one write-back", wr_cnt, w0 + 1);
        check(last_wb_addr == mk(0, 1, 2), "R8 write-back address", int'(last_wb_addr), int'(mk(0, 1, 2)));
        access(mk(0, 1, 2), 1'b0, '0, h, d);
        check(d == 16'h1234, "R2 data survives eviction", int'(d), 16'h1234);

        // R10: write miss allocates then stores
        access(mk(2, 9, 3), 1'b1, 16'hcafe, h, d);
        check(h == 1'b0, "R10 write miss", int'(h), 0);
        access(mk(2, 9, 3), 1'b0, '0, h, d);
        check(h == 1'b1 && d == 16'hcafe, "R10 allocated write", int'(d), 16'hcafe);

        // R2: sweep every address with mixed writes, then re-read all
        for (int i = 0; i < DEPTH; i++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'((i * 7 + 3) % DEPTH);
            if (i % 3 == 0) access(a, 1'b1, DATA_W'(i) ^ 16'hbeef, h, d);
            else begin
                access(a, 1'b0, '0, h, d);
                check(d == gold[a], "R2 sweep read", int'(d), int'(gold[a]));
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            access(ADDR_W'(i), 1'b0, '0, h, d);
            check(d == gold[i], "R2 final read", int'(d), int'(gold[i]));
        end
        check(stall_bad == 0, "R9 stall handshake", stall_bad, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule